// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block holds a bank of outbound translation regions that map CPU-side addresses onto bus addresses for a PCI Express root port. Each region has a 64-bit base, a 32-bit limit, a 64-bit target and a control pair that gives its enable, its transaction kind and an optional configuration shift mode. Software reaches the regions indirectly. It first writes a viewport register to pick one region, then reads or writes that region's fields at a small group of fixed offsets.

On the request side, one address is accepted per cycle over a valid/ready stream. The address is compared against every enabled region at once. The lowest-numbered region that matches supplies the translated address and the transaction kind. An address that matches no region comes out unchanged, with a miss flag set.

Responses appear on a valid/ready stream one cycle after acceptance. The response stage holds one entry. `req_ready` is high whenever that stage is empty or is being drained in the same cycle, so a full stream with `resp_ready` held high runs at one address per cycle. While `resp_ready` is low and a response is waiting, `req_ready` stays low and the held response does not change.

Top module: `atu_outbound_xlate`

## Requirements
- R1: The viewport register at offset 0x900 holds a region index in bits [2:0] and a direction bit in bit 31 (1 = inbound, 0 = outbound). It reads back with all other bits zero, and writing it never changes the contents of any region.
- R2: Region fields sit at these offsets: 0x904 kind, 0x908 control, 0x90C base low, 0x910 base high, 0x914 limit, 0x918 target low, 0x91C target high. They access the region selected by the viewport, and a write is visible from the next cycle. Offset 0x904 keeps only bits [2:0]. Offset 0x908 keeps only bit 31 (enable) and bit 28 (shift). All other bits of both read as zero, and unmapped offsets read as zero.
- R3: While the viewport direction bit is 1, writes to the region offsets are ignored and reads of them return zero.
- R4: A region matches an address when it is enabled, address[63:32] equals base[63:32], and address[31:0] lies between base[31:0] and the limit, both ends included.
- R5: A region whose enable bit is 0 never matches, whatever its other fields hold.
- R6: Outside shift mode, the translated address is target + (address - base), computed modulo 2^64.
- R7: The response kind equals the matching region's kind field. The kind codes are memory = 0, I/O = 2, type 0 configuration = 4 and type 1 configuration = 5.
- R8: In shift mode the translated address is {target[63:32], address[27:12], 4'h0, address[11:0]}, which places bus/device/function in bits [31:16].
- R9: When several enabled regions match, the lowest-numbered one supplies the result, and its index is reported on `resp_region`.
- R10: An address with no match is returned unchanged, with `resp_miss` = 1, kind 0 and region 0.
- R11: A request accepted on a rising edge produces its response in the next cycle. While `resp_valid` is high and `resp_ready` is low, `req_ready` is low and the response fields hold steady.
- R12: After reset all regions are cleared and disabled, the viewport reads zero, and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 64 | CPU-side address |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_addr | output | 64 | Translated (or passed-through) address |
| resp_kind | output | 3 | Transaction kind code |
| resp_miss | output | 1 | No region matched |
| resp_region | output | 3 | Index of the winning region |

## Verification
Region state written under the wrong viewport index, or a field stored in the wrong region, shows up the very next cycle: reading back through the viewport returns the wrong value at `cfg_rdata`. A wrong match or priority decision shows up on the response one cycle after the request is accepted. It appears as the wrong `resp_region` or `resp_kind`, or as a miss where a hit was due. Arithmetic faults in offset or shift translation show up only in `resp_addr`. Test addresses are therefore chosen at region edges and with distinct bit patterns, so that such faults change visible bits.

// File: rtl/atu_pkg.sv
package atu_pkg;

  localparam int unsigned ADDR_W = 64;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned KIND_W = 3;
  localparam int unsigned OFF_W  = 12;

  localparam logic [OFF_W-1:0] OFF_VIEWPORT = 12'h900;
  localparam logic [OFF_W-1:0] OFF_KIND     = 12'h904;
  localparam logic [OFF_W-1:0] OFF_CTRL     = 12'h908;
  localparam logic [OFF_W-1:0] OFF_BASE_LO  = 12'h90C;
  localparam logic [OFF_W-1:0] OFF_BASE_HI  = 12'h910;
  localparam logic [OFF_W-1:0] OFF_LIMIT    = 12'h914;
  localparam logic [OFF_W-1:0] OFF_TGT_LO   = 12'h918;
  localparam logic [OFF_W-1:0] OFF_TGT_HI   = 12'h91C;

  localparam int unsigned CTRL_EN_BIT    = 31;
  localparam int unsigned CTRL_SHIFT_BIT = 28;
  localparam int unsigned VP_DIR_BIT     = 31;

  typedef enum logic [KIND_W-1:0] {
    XK_MEM  = 3'd0,
    XK_IO   = 3'd2,
    XK_CFG0 = 3'd4,
    XK_CFG1 = 3'd5
  } xlate_kind_e;

  typedef struct packed {
    logic                en;
    logic                shift;
    logic [KIND_W-1:0]   kind;
    logic [ADDR_W-1:0]   base;
    logic [HALF_W-1:0]   limit;
    logic [ADDR_W-1:0]   target;
  } region_t;

endpackage

// File: rtl/atu_regfile.sv
module atu_regfile
  import atu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [OFF_W-1:0]              addr,
  input  logic [HALF_W-1:0]             wdata,
  output logic [HALF_W-1:0]             rdata,
  output region_t [NUM_REGIONS-1:0]     regs,
  output logic [IDX_W-1:0]              vp_idx,
  output logic                          vp_inbound
);

  localparam int unsigned VP_PAD = HALF_W - 1 - IDX_W;

  // Viewport: only the index and direction are kept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp_idx     <= '0;
      vp_inbound <= 1'b0;
    end else if (wr_en && addr == OFF_VIEWPORT) begin
      vp_idx     <= wdata[IDX_W-1:0];
      vp_inbound <= wdata[VP_DIR_BIT];
    end
  end

  // One storage slice per region, written only when the viewport points at it
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    region_t q;
    logic    hit_sel;

    assign hit_sel = wr_en && !vp_inbound && (vp_idx == IDX_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit_sel) begin
        case (addr)
          OFF_KIND:    q.kind          <= wdata[KIND_W-1:0];
          OFF_CTRL: begin
            q.en    <= wdata[CTRL_EN_BIT];
            q.shift <= wdata[CTRL_SHIFT_BIT];
          end
          OFF_BASE_LO: q.base[31:0]    <= wdata;
          OFF_BASE_HI: q.base[63:32]   <= wdata;
          OFF_LIMIT:   q.limit         <= wdata;
          OFF_TGT_LO:  q.target[31:0]  <= wdata;
          OFF_TGT_HI:  q.target[63:32] <= wdata;
          default: ;
        endcase
      end
    end

    assign regs[r] = q;
  end

  // Read path: selected region, zero when inbound or unmapped
  region_t sel;

  always_comb begin
    sel = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (!vp_inbound && vp_idx == IDX_W'(r)) begin
        sel = regs[r];
      end
    end
  end

  always_comb begin
    case (addr)
      OFF_VIEWPORT: rdata = {vp_inbound, {VP_PAD{1'b0}}, vp_idx};
      OFF_KIND:     rdata = {{(HALF_W-KIND_W){1'b0}}, sel.kind};
      OFF_CTRL:     rdata = {sel.en, 2'b00, sel.shift, 28'h0000000};
      OFF_BASE_LO:  rdata = sel.base[31:0];
      OFF_BASE_HI:  rdata = sel.base[63:32];
      OFF_LIMIT:    rdata = sel.limit;
      OFF_TGT_LO:   rdata = sel.target[31:0];
      OFF_TGT_HI:   rdata = sel.target[63:32];
      default:      rdata = '0;
    endcase
  end

endmodule

// File: rtl/atu_region_match.sv
module atu_region_match
  import atu_pkg::*;
(
  input  region_t            cfg,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [ADDR_W-1:0]  xlat
);

  logic upper_eq;
  logic above_base;
  logic below_limit;

  assign upper_eq    = (addr[63:32] == cfg.base[63:32]);
  assign above_base  = (addr[31:0] >= cfg.base[31:0]);
  assign below_limit = (addr[31:0] <= cfg.limit);
  assign hit         = cfg.en && upper_eq && above_base && below_limit;

  always_comb begin
    if (cfg.shift) begin
      xlat = {cfg.target[63:32], addr[27:12], 4'h0, addr[11:0]};
    end else begin
      xlat = cfg.target + (addr - cfg.base);
    end
  end

endmodule

// File: rtl/atu_pick.sv
module atu_pick
  import atu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic [NUM_REGIONS-1:0]              hit_vec,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  xlat_all,
  input  logic [NUM_REGIONS-1:0][KIND_W-1:0]  kind_all,
  input  logic [ADDR_W-1:0]                   pass_addr,
  output logic [NUM_REGIONS-1:0]              win_vec,
  output logic                                any_hit,
  output logic [ADDR_W-1:0]                   out_addr,
  output logic [KIND_W-1:0]                   out_kind,
  output logic [IDX_W-1:0]                    out_idx
);

  // Isolate the lowest set bit: lowest index has priority
  assign win_vec = hit_vec & (~hit_vec + NUM_REGIONS'(1));
  assign any_hit = |hit_vec;

  always_comb begin
    out_addr = pass_addr;
    out_kind = XK_MEM;
    out_idx  = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (win_vec[r]) begin
        out_addr = xlat_all[r];
        out_kind = kind_all[r];
        out_idx  = IDX_W'(r);
      end
    end
  end

endmodule

// File: rtl/atu_outbound_xlate.sv
module atu_outbound_xlate
  import atu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [11:0]        cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [63:0]        req_addr,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic [63:0]        resp_addr,
  output logic [2:0]         resp_kind,
  output logic               resp_miss,
  output logic [IDX_W-1:0]   resp_region
);

  region_t [NUM_REGIONS-1:0]              regs;
  logic [IDX_W-1:0]                       vp_idx;
  logic                                   vp_inbound;
  logic [NUM_REGIONS-1:0]                 hit_vec;
  logic [NUM_REGIONS-1:0]                 win_vec;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0]     xlat_all;
  logic [NUM_REGIONS-1:0][KIND_W-1:0]     kind_all;
  logic                                   any_hit;
  logic [ADDR_W-1:0]                      sel_addr;
  logic [KIND_W-1:0]                      sel_kind;
  logic [IDX_W-1:0]                       sel_idx;

  atu_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .regs       (regs),
    .vp_idx     (vp_idx),
    .vp_inbound (vp_inbound)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_match
    atu_region_match u_match (
      .cfg  (regs[r]),
      .addr (req_addr),
      .hit  (hit_vec[r]),
      .xlat (xlat_all[r])
    );
    assign kind_all[r] = regs[r].kind;
  end

  atu_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
    .hit_vec   (hit_vec),
    .xlat_all  (xlat_all),
    .kind_all  (kind_all),
    .pass_addr (req_addr),
    .win_vec   (win_vec),
    .any_hit   (any_hit),
    .out_addr  (sel_addr),
    .out_kind  (sel_kind),
    .out_idx   (sel_idx)
  );

  // Single-entry response stage
  assign req_ready = !resp_valid || resp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_addr   <= '0;
      resp_kind   <= '0;
      resp_miss   <= 1'b0;
      resp_region <= '0;
    end else if (req_valid && req_ready) begin
      resp_valid  <= 1'b1;
      resp_addr   <= sel_addr;
      resp_kind   <= sel_kind;
      resp_miss   <= !any_hit;
      resp_region <= sel_idx;
    end else if (resp_ready) begin
      resp_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/atu_xlate_chk.sv
module atu_xlate_chk
  import atu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_wr,
  input logic [11:0]                cfg_addr,
  input logic [31:0]                cfg_wdata,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [63:0]                req_addr,
  input logic                       resp_valid,
  input logic                       resp_ready,
  input logic [63:0]                resp_addr,
  input logic [2:0]                 resp_kind,
  input logic                       resp_miss,
  input region_t [NUM_REGIONS-1:0]  regs,
  input logic [NUM_REGIONS-1:0]     win_vec,
  input logic [IDX_W-1:0]           vp_idx,
  input logic                       vp_inbound
);

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_addr)
                                  && $stable(resp_kind) && $stable(resp_miss));

  a_r11_accept_responds: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);

  a_r1_viewport_keeps_regions: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr == OFF_VIEWPORT |=> $stable(regs));

  a_r1_viewport_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr == OFF_VIEWPORT |=> vp_idx == $past(cfg_wdata[IDX_W-1:0]));

  a_r3_inbound_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && vp_inbound && cfg_addr != OFF_VIEWPORT |=> $stable(regs));

  a_r9_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec));

  a_r10_miss_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (win_vec == '0) |=> resp_miss && resp_addr == $past(req_addr));

endmodule

bind atu_outbound_xlate atu_xlate_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_addr  (resp_addr),
  .resp_kind  (resp_kind),
  .resp_miss  (resp_miss),
  .regs       (regs),
  .win_vec    (win_vec),
  .vp_idx     (vp_idx),
  .vp_inbound (vp_inbound)
);

// File: tb/tb_atu_outbound_xlate.sv
module tb_atu_outbound_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [63:0] resp_addr;
  logic [2:0]  resp_kind;
  logic        resp_miss;
  logic [2:0]  resp_region;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  atu_outbound_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_addr(resp_addr),
    .resp_kind(resp_kind), .resp_miss(resp_miss), .resp_region(resp_region)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_expect(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  task automatic program_region(input int idx, input logic [2:0] kind, input logic [31:0] ctrl,
                                input logic [63:0] base, input logic [31:0] limit,
                                input logic [63:0] tgt);
    cfg_write(12'h900, 32'(idx));
    cfg_write(12'h904, {29'h0, kind});
    cfg_write(12'h90C, base[31:0]);
    cfg_write(12'h910, base[63:32]);
    cfg_write(12'h914, limit);
    cfg_write(12'h918, tgt[31:0]);
    cfg_write(12'h91C, tgt[63:32]);
    cfg_write(12'h908, ctrl);
  endtask

  task automatic xlate_expect(input string req, input logic [63:0] a, input logic [63:0] exp_addr,
                              input logic [2:0] exp_kind, input logic exp_miss,
                              input logic [2:0] exp_region);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {63'h0, resp_valid}, 64'h1);
    check({req, " addr"}, resp_addr, exp_addr);
    check({req, " kind"}, {61'h0, resp_kind}, {61'h0, exp_kind});
    check({req, " miss"}, {63'h0, resp_miss}, {63'h0, exp_miss});
    check({req, " region"}, {61'h0, resp_region}, {61'h0, exp_region});
  endtask

  task automatic t_reset;
    check("R12 resp_valid after reset", {63'h0, resp_valid}, 64'h0);
    cfg_expect("R12 viewport after reset", 12'h900, 32'h0);
    cfg_expect("R12 ctrl after reset", 12'h908, 32'h0);
    cfg_expect("R12 limit after reset", 12'h914, 32'h0);
    xlate_expect("R12 no region hits after reset", 64'h0000_0000_4000_0000,
                 64'h0000_0000_4000_0000, 3'd0, 1'b1, 3'd0);
  endtask

  task automatic t_viewport;
    cfg_write(12'h900, 32'hFFFF_FFF5);
    cfg_expect("R1 viewport readback", 12'h900, 32'h8000_0005);
    cfg_write(12'h900, 32'h0000_0007);
    cfg_expect("R1 viewport outbound", 12'h900, 32'h0000_0007);
  endtask

  task automatic t_region_rw;
    cfg_write(12'h900, 32'h7);
    cfg_write(12'h904, 32'hFFFF_FFFD);
    cfg_expect("R2 kind reserved bits", 12'h904, 32'h0000_0005);
    cfg_write(12'h908, 32'hFFFF_FFFF);
    cfg_expect("R2 ctrl reserved bits", 12'h908, 32'h9000_0000);
    cfg_write(12'h90C, 32'hA5A5_0000);
    cfg_write(12'h910, 32'hFFFF_FFFF);
    cfg_write(12'h914, 32'hA5A5_FFFF);
    cfg_write(12'h918, 32'h1357_9BDF);
    cfg_write(12'h91C, 32'h0246_8ACE);
    cfg_expect("R2 base lo", 12'h90C, 32'hA5A5_0000);
    cfg_expect("R2 base hi", 12'h910, 32'hFFFF_FFFF);
    cfg_expect("R2 limit", 12'h914, 32'hA5A5_FFFF);
    cfg_expect("R2 target lo", 12'h918, 32'h1357_9BDF);
    cfg_expect("R2 target hi", 12'h91C, 32'h0246_8ACE);
    cfg_expect("R2 unmapped offset", 12'h920, 32'h0);
    cfg_write(12'h900, 32'h6);
    cfg_expect("R2 other region untouched", 12'h90C, 32'h0);
    cfg_write(12'h900, 32'h7);
    cfg_expect("R1 region kept across viewport change", 12'h90C, 32'hA5A5_0000);
  endtask

  task automatic t_inbound;
    cfg_write(12'h900, 32'h8000_0007);
    cfg_write(12'h90C, 32'h0000_1234);
    cfg_expect("R3 inbound read zero", 12'h90C, 32'h0);
    cfg_expect("R3 viewport shows inbound", 12'h900, 32'h8000_0007);
    cfg_write(12'h900, 32'h7);
    cfg_expect("R3 inbound write ignored", 12'h90C, 32'hA5A5_0000);
  endtask

  task automatic t_program_all;
    program_region(0, 3'd0, 32'h8000_0000, 64'h0000_0000_4000_0000, 32'h4FFF_FFFF, 64'h0000_0001_0000_0000);
    program_region(1, 3'd4, 32'h9000_0000, 64'h0000_0000_6000_0000, 32'h6000_FFFF, 64'h0);
    program_region(2, 3'd5, 32'h9000_0000, 64'h0000_0000_6001_0000, 32'h6FFF_FFFF, 64'h0000_0002_0000_0000);
    program_region(3, 3'd2, 32'h8000_0000, 64'h0000_0008_0001_0000, 32'h0001_FFFF, 64'h0);
    program_region(4, 3'd0, 32'h8000_0000, 64'h0000_0000_4000_0000, 32'h4000_0FFF, 64'h0000_0000_7000_0000);
    program_region(5, 3'd0, 32'h0000_0000, 64'h0000_0000_9000_0000, 32'h9FFF_FFFF, 64'h0000_0000_1000_0000);
  endtask

  task automatic t_memory;
    xlate_expect("R6 mem offset", 64'h0000_0000_4012_3454, 64'h0000_0001_0012_3454, 3'd0, 1'b0, 3'd0);
    xlate_expect("R4 limit inclusive", 64'h0000_0000_4FFF_FFFF, 64'h0000_0001_0FFF_FFFF, 3'd0, 1'b0, 3'd0);
    xlate_expect("R4 above limit", 64'h0000_0000_5000_0000, 64'h0000_0000_5000_0000, 3'd0, 1'b1, 3'd0);
    xlate_expect("R4 below base", 64'h0000_0000_3FFF_FFFF, 64'h0000_0000_3FFF_FFFF, 3'd0, 1'b1, 3'd0);
  endtask

  task automatic t_io_upper;
    xlate_expect("R7 io kind", 64'h0000_0008_0001_0010, 64'h0000_0000_0000_0010, 3'd2, 1'b0, 3'd3);
    xlate_expect("R4 upper word mismatch", 64'h0000_0000_0001_0010, 64'h0000_0000_0001_0010, 3'd0, 1'b1, 3'd0);
  endtask

  task automatic t_config_shift;
    xlate_expect("R8 cfg0 shift", 64'h0000_0000_6000_A123, 64'h0000_0000_000A_0123, 3'd4, 1'b0, 3'd1);
    xlate_expect("R8 cfg1 shift", 64'h0000_0000_6123_4567, 64'h0000_0002_1234_0567, 3'd5, 1'b0, 3'd2);
  endtask

  task automatic t_disabled;
    xlate_expect("R5 disabled region", 64'h0000_0000_9000_0000, 64'h0000_0000_9000_0000, 3'd0, 1'b1, 3'd0);
  endtask

  task automatic t_priority;
    xlate_expect("R9 lowest index wins", 64'h0000_0000_4000_0010, 64'h0000_0001_0000_0010, 3'd0, 1'b0, 3'd0);
    cfg_write(12'h900, 32'h0);
    cfg_write(12'h908, 32'h0);
    xlate_expect("R9 next region after disable", 64'h0000_0000_4000_0010, 64'h0000_0000_7000_0010, 3'd0, 1'b0, 3'd4);
    cfg_write(12'h908, 32'h8000_0000);
  endtask

  task automatic t_backpressure;
    resp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h0000_0000_4000_0020;
    @(negedge clk);
    check("R11 resp after one cycle", {63'h0, resp_valid}, 64'h1);
    check("R11 ready low while stalled", {63'h0, req_ready}, 64'h0);
    req_addr = 64'h0000_0000_5555_0000;
    @(negedge clk);
    check("R11 held addr", resp_addr, 64'h0000_0001_0000_0020);
    check("R11 still valid", {63'h0, resp_valid}, 64'h1);
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 second request addr", resp_addr, 64'h0000_0000_5555_0000);
    check("R10 second request miss", {63'h0, resp_miss}, 64'h1);
    @(negedge clk);
    check("R11 drained", {63'h0, resp_valid}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_viewport();
    t_region_rw();
    t_inbound();
    t_program_all();
    t_memory();
    t_io_upper();
    t_config_shift();
    t_disabled();
    t_priority();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule